// File: doc/BRIEF.md
# Odd-Value Up/Down Sequence Counter

This block is a synchronous 3-bit counter that visits only the values 0, 1, 3, 5 and 7. A direction input chooses forward or reverse traversal. It does not add or subtract one. Each state bit sits in a JK-style flip-flop, and combinational excitation logic derived from a custom next-value map drives its J and K inputs. The codes 2, 4 and 6 never occur in normal counting. If the register ever holds one of them, the next enabled clock edge returns it to 0.

The present value appears on three outputs: the raw state, a 4-bit BCD digit and an active-high seven-segment pattern for a single display digit. All three are registered and change together on the same clock edge. The reset value is a parameter that defaults to 0. A non-default value lets an instance start on any code, including an unused one.

Top module: `skip_seq_counter`

## Requirements
- R1: A clock edge with `rst_i` high loads the state with `RESET_CODE` (default 0), whatever `en_i` is. `bcd_o` and `seg_o` show that value on the same edge.
- R2: While `rst_i` is low and `en_i` is low, `count_o`, `bcd_o` and `seg_o` keep their values across clock edges.
- R3: With `up_i` high (1 = forward), each enabled edge steps the state 0 to 1, 1 to 3, 3 to 5, 5 to 7 and 7 to 0, repeating without end.
- R4: With `up_i` low (0 = reverse), each enabled edge steps the state 0 to 7, 7 to 5, 5 to 3, 3 to 1 and 1 to 0, repeating without end.
- R5: A change of `up_i` takes effect on the next enabled edge. Counting continues from the current value, with no reset and no lost step.
- R6: From code 2, 4 or 6, the next enabled edge moves the state to 0 in either direction.
- R7: `bcd_o` always equals the state as an unsigned value, with bit 3 equal to 0.
- R8: `seg_o` is active high with bit 0 = segment a through bit 6 = segment g. The digits map as follows (hex, g..a): 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07. `seg_o` always shows the pattern of the current state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by every flip-flop |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Count enable; the state holds when low |
| up_i | input | 1 | Direction: 1 forward, 0 reverse |
| count_o | output | 3 | Present state |
| bcd_o | output | 4 | Present state as a BCD digit |
| seg_o | output | 7 | Active-high segments, bit 0 = a through bit 6 = g |

## Verification
The bench builds four copies of the counter with `RESET_CODE` set to 0, 2, 4 and 6. The three non-zero copies start the counter on each unused code, which puts the recovery path within reach from reset alone, in both directions and without any load port. The default copy is swept through more than two full wraps in each direction. It is then driven by a pseudo-random mix of enable and direction values, so that every reversal point and every hold case is met. At each step, the bench compares all three outputs of every copy against an arithmetic model of the sequence and a segment table.

// File: rtl/skip_seq_pkg.sv
`timescale 1ns/1ps
package skip_seq_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned SEG_W  = 7;
  localparam int unsigned BCD_W  = 4;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [BCD_W-1:0]  bcd_t;

  typedef struct packed {
    code_t j;
    code_t k;
  } jk_drive_t;

  // Active-high segments, bit 0 = a ... bit 6 = g
  function automatic seg_t seg_pattern(input code_t v);
    seg_t s;
    case (v)
      3'd0:    s = 7'h3F;
      3'd1:    s = 7'h06;
      3'd2:    s = 7'h5B;
      3'd3:    s = 7'h4F;
      3'd4:    s = 7'h66;
      3'd5:    s = 7'h6D;
      3'd6:    s = 7'h7D;
      default: s = 7'h07;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/skip_seq_excite.sv
`timescale 1ns/1ps
module skip_seq_excite
  import skip_seq_pkg::*;
(
  input  code_t     q_i,
  input  logic      up_i,
  output code_t     nxt_o,
  output jk_drive_t drv_o
);
  code_t nxt;

  // Next-value map; unused codes fall to zero
  always_comb begin
    case (q_i)
      3'd0:    nxt = up_i ? 3'd1 : 3'd7;
      3'd1:    nxt = up_i ? 3'd3 : 3'd0;
      3'd3:    nxt = up_i ? 3'd5 : 3'd1;
      3'd5:    nxt = up_i ? 3'd7 : 3'd3;
      3'd7:    nxt = up_i ? 3'd0 : 3'd5;
      default: nxt = 3'd0;
    endcase
  end

  // Per-bit excitation: J sets a cleared bit, K clears a set bit
  for (genvar b = 0; b < CODE_W; b++) begin : g_exc
    assign drv_o.j[b] = ~q_i[b] &  nxt[b];
    assign drv_o.k[b] =  q_i[b] & ~nxt[b];
  end

  assign nxt_o = nxt;
endmodule

// File: rtl/skip_seq_jkbank.sv
`timescale 1ns/1ps
module skip_seq_jkbank
  import skip_seq_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      en_i,
  input  jk_drive_t drv_i,
  output code_t     q_o
);
  code_t q;

  for (genvar b = 0; b < CODE_W; b++) begin : g_ff
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        q[b] <= RESET_CODE[b];
      end else if (en_i) begin
        case ({drv_i.j[b], drv_i.k[b]})
          2'b01:   q[b] <= 1'b0;
          2'b10:   q[b] <= 1'b1;
          2'b11:   q[b] <= ~q[b];
          default: q[b] <= q[b];
        endcase
      end
    end
  end

  assign q_o = q;

  // R2: state frozen while enable is low
  a_r2_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/skip_seq_display.sv
`timescale 1ns/1ps
module skip_seq_display
  import skip_seq_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  en_i,
  input  code_t nxt_i,
  input  code_t cnt_i,
  output bcd_t  bcd_o,
  output seg_t  seg_o
);
  bcd_t bcd_q;
  seg_t seg_q;

  // Registered from the next value so outputs align with the state
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bcd_q <= {1'b0, RESET_CODE};
      seg_q <= seg_pattern(RESET_CODE);
    end else if (en_i) begin
      bcd_q <= {1'b0, nxt_i};
      seg_q <= seg_pattern(nxt_i);
    end
  end

  assign bcd_o = bcd_q;
  assign seg_o = seg_q;

  // R7: BCD digit tracks the state register
  a_r7_bcd_track: assert property (@(posedge clk_i) disable iff (rst_i)
    bcd_o == {1'b0, cnt_i});
  // R8: segments show the pattern of the state register
  a_r8_seg_track: assert property (@(posedge clk_i) disable iff (rst_i)
    seg_o == seg_pattern(cnt_i));
endmodule

// File: rtl/skip_seq_counter.sv
`timescale 1ns/1ps
module skip_seq_counter
  import skip_seq_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             up_i,
  output logic [CODE_W-1:0] count_o,
  output logic [BCD_W-1:0]  bcd_o,
  output logic [SEG_W-1:0]  seg_o
);
  code_t     state;
  code_t     nxt;
  jk_drive_t drv;

  skip_seq_excite u_excite (
    .q_i   (state),
    .up_i  (up_i),
    .nxt_o (nxt),
    .drv_o (drv)
  );

  skip_seq_jkbank #(.RESET_CODE(RESET_CODE)) u_bank (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .drv_i (drv),
    .q_o   (state)
  );

  skip_seq_display #(.RESET_CODE(RESET_CODE)) u_disp (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .nxt_i (nxt),
    .cnt_i (state),
    .bcd_o (bcd_o),
    .seg_o (seg_o)
  );

  assign count_o = state;

  // R1: reset loads the parameter value
  a_r1_reset_load: assert property (@(posedge clk_i)
    rst_i |=> count_o == RESET_CODE);
  // R3: forward wrap from 7
  a_r3_up_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && up_i && count_o == 3'd7) |=> count_o == 3'd0);
  // R4: reverse wrap from 0
  a_r4_down_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !up_i && count_o == 3'd0) |=> count_o == 3'd7);
  // R6: unused codes recover to zero
  a_r6_recover: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && (count_o == 3'd2 || count_o == 3'd4 || count_o == 3'd6))
      |=> count_o == 3'd0);
endmodule

// File: tb/skip_seq_counter_tb.sv
`timescale 1ns/1ps
module skip_seq_counter_tb_top;
  localparam int NDUT = 4;
  localparam logic [2:0] RCODE [NDUT] = '{3'd0, 3'd2, 3'd4, 3'd6};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic up  = 1'b1;
  always #5 clk = ~clk;

  logic [2:0] cnt [NDUT];
  logic [3:0] bcd [NDUT];
  logic [6:0] seg [NDUT];
  logic [2:0] expv [NDUT];

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  skip_seq_counter #(.RESET_CODE(RCODE[0])) dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .up_i(up),
    .count_o(cnt[0]), .bcd_o(bcd[0]), .seg_o(seg[0]));

  for (genvar d = 1; d < NDUT; d++) begin : g_ill
    skip_seq_counter #(.RESET_CODE(RCODE[d])) dut_ill (
      .clk_i(clk), .rst_i(rst), .en_i(en), .up_i(up),
      .count_o(cnt[d]), .bcd_o(bcd[d]), .seg_o(seg[d]));
  end

  function automatic logic [2:0] model_next(logic [2:0] v, logic u);
    int x = int'(v);
    if (u) begin
      if (x == 0) return 3'd1;
      if (x == 7) return 3'd0;
      if (x % 2 == 1) return 3'(x + 2);
      return 3'd0;
    end
    if (x == 0) return 3'd7;
    if (x == 1) return 3'd0;
    if (x % 2 == 1) return 3'(x - 2);
    return 3'd0;
  endfunction

  function automatic logic [6:0] seg_exp(logic [2:0] v);
    logic [6:0] t [8] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07};
    return t[v];
  endfunction

  task automatic check(string tag, int d, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s dut%0d: actual %0h expected %0h", tag, d, act, exp);
    end
  endtask

  // Drive at negedge, take one posedge, check at the following negedge
  task automatic cyc(logic r, logic e, logic u, string tag);
    rst = r; en = e; up = u;
    @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < NDUT; d++) begin
      if (r) expv[d] = RCODE[d];
      else if (e) expv[d] = model_next(expv[d], u);
      check(tag, d, int'(cnt[d]), int'(expv[d]));
      check({tag, "/R7"}, d, int'(bcd[d]), int'(expv[d]));
      check({tag, "/R8"}, d, int'(seg[d]), int'(seg_exp(expv[d])));
    end
  endtask

  initial begin
    logic [7:0] lf = 8'hA5;
    @(negedge clk);
    // R1: reset, also with enable high
    cyc(1'b1, 1'b0, 1'b1, "R1");
    cyc(1'b1, 1'b1, 1'b0, "R1");
    // R2: hold with enable low, both directions
    cyc(1'b0, 1'b0, 1'b1, "R2");
    cyc(1'b0, 1'b0, 1'b0, "R2");
    cyc(1'b0, 1'b0, 1'b1, "R2");
    // R6: recovery going forward
    cyc(1'b0, 1'b1, 1'b1, "R6_up");
    // R6: recovery going backward
    cyc(1'b1, 1'b0, 1'b0, "R1");
    cyc(1'b0, 1'b1, 1'b0, "R6_down");
    // R3: forward sweep, more than two wraps
    cyc(1'b1, 1'b0, 1'b1, "R1");
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, 1'b1, "R3");
    // R4: reverse sweep, more than two wraps
    cyc(1'b1, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, 1'b0, "R4");
    // R5: mixed direction and enable
    for (int i = 0; i < 200; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      cyc(1'b0, |lf[1:0], lf[2], "R5");
    end
    // R5: reversal at each legal value
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 1'b1, 1'b1, "R5");
      cyc(1'b0, 1'b1, 1'b0, "R5");
      cyc(1'b0, 1'b1, 1'b1, "R5");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule